// File: doc/BRIEF.md
# Multiplexed Memory Access Timing Sequencer

This block turns single read or write requests from an internal requester into the pin sequence needed by an external asynchronous memory, such as NOR flash, that shares one set of wires between address and data. Every access passes through four phases in fixed order: address setup, address hold, data, and bus turnaround. The length of each phase is programmed in system-clock cycles through a configuration word.

The configuration word also carries a bank enable, a multiplex enable and a memory data width. It is sampled once, when a request is accepted, so it may change during an access without effect. The requester raises `req_valid` with the direction, address and write data and holds them until `req_ack` pulses. For reads, the captured data is on `req_rdata` in the same cycle as the acknowledge.

The external bus is split into `bus_out`, `bus_oe` and `bus_in` so that a pad ring can form the tristate. A separate `mem_addr` output carries the full address for the whole access. Memories that are not multiplexed use this output.

Top module: `mux_mem_seq`

## Requirements
- R1: Configuration word layout: bit 0 is bank enable, bit 1 is multiplex enable, bits 3:2 are width (00 = 8-bit, any other value = 16-bit), bits 7:4 are setup, bits 11:8 are hold, bits 19:12 are data, and bits 23:20 are turnaround. While bank enable is 0, a pending request starts no access: chip select stays high and no acknowledge is given.
- R2: Address setup lasts setup+1 cycles. Chip select is low throughout. With multiplexing on, the address-valid strobe is low and the bus drives the address.
- R3: Address hold lasts hold+1 cycles, with a hold value of 0 treated as 1. The strobe is high and, with multiplexing on, the address stays driven on the bus.
- R4: The data phase lasts d+3 cycles for a read and d+1 cycles for a write, where d is the data field and a value of 0 is treated as 1.
- R5: Turnaround lasts turn+1 cycles with chip select, output enable and write enable all high. The acknowledge is high for exactly the one cycle after turnaround ends.
- R6: In a write data phase, write enable is low and output enable is high. The bus is driven with the write data, and the bits above bit 7 are forced to 0 in 8-bit width.
- R7: In a read data phase, the bus driver is off and output enable is low. `bus_in` is sampled on the last cycle of the phase, masked to 8 bits in 8-bit width, and presented on `req_rdata` together with the acknowledge.
- R8: With multiplexing off, the strobe never goes low and the bus is not driven during setup or hold. `mem_addr` equals the request address whenever chip select is low.
- R9: Only one access runs at a time. A request still held in the acknowledge cycle does not start a second access. Configuration changes during an access do not alter it.
- R10: During and after reset, chip select, strobe, output enable and write enable are high, the bus driver is off, the acknowledge is low, and `req_rdata` is 0. A reset during an access ends it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 24 | Phase lengths, width, multiplex and bank enables |
| req_valid | input | 1 | Request pending, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | BUS_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | BUS_W | Read data, valid with the acknowledge |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Full address for non-multiplexed memories |
| bus_out | output | BUS_W | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable |
| bus_in | input | BUS_W | Value read from the shared bus |

## Verification
The request is accepted on the clock edge that first sees it pending. Setup begins in the next cycle, and the acknowledge arrives exactly setup+hold+data+turnaround phase lengths after the accepting edge. The bench samples every output at the falling edge. It counts in which cycle after acceptance each strobe is low and compares the phase lengths, the total latency and the read data against values derived from the configuration fields. Its memory model changes `bus_in` on every output-enable cycle, so only a capture on the last data cycle produces the expected value.

// File: rtl/mms_pkg.sv
// Package: shared types for the multiplexed memory sequencer.
// Assumes the configuration layout described in the brief (24 bits).
package mms_pkg;

    localparam int CFG_W = 24;

    // Access phase encoding
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_HOLD  = 3'd2,
        PH_DATA  = 3'd3,
        PH_TURN  = 3'd4
    } phase_t;

    // Configuration word, most significant field first
    typedef struct packed {
        logic [3:0] turn;
        logic [7:0] data;
        logic [3:0] hold;
        logic [3:0] setup;
        logic [1:0] width;
        logic       mux_en;
        logic       bank_en;
    } cfg_t;

endpackage

// File: rtl/mms_phase_ctl.sv
// Phase controller: accepts one request at a time, snapshots the
// configuration and walks setup, hold, data and turnaround with a
// down-counter, then pulses the acknowledge.
// Assumes the requester holds req_valid until the acknowledge.
module mms_phase_ctl
    import mms_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   req_write,
    input  cfg_t   cfg,
    output phase_t phase,
    output logic   last,
    output logic   write_q,
    output cfg_t   cfg_q,
    output logic   start,
    output logic   ack
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_setup, len_hold, len_data, len_turn;
    logic [3:0]       hold_eff;
    logic [7:0]       data_eff;

    // Phase lengths minus one, with zero fields raised to one
    always_comb begin
        hold_eff  = (cfg_q.hold == 4'd0) ? 4'd1 : cfg_q.hold;
        data_eff  = (cfg_q.data == 8'd0) ? 8'd1 : cfg_q.data;
        len_setup = CNT_W'(cfg.setup);
        len_hold  = CNT_W'(hold_eff);
        len_data  = write_q ? CNT_W'(data_eff) : CNT_W'(data_eff) + CNT_W'(2);
        len_turn  = CNT_W'(cfg_q.turn);
    end

    // Accept only from idle, outside the acknowledge cycle, with bank on
    assign start = (phase == PH_IDLE) && !ack && req_valid && cfg.bank_en;
    assign last  = (phase != PH_IDLE) && (cnt == '0);

    // Phase sequencing and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            ack     <= 1'b0;
            write_q <= 1'b0;
            cfg_q   <= '0;
        end else begin
            ack <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_SETUP;
                        cnt     <= len_setup;
                        cfg_q   <= cfg;
                        write_q <= req_write;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= len_hold;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        phase <= PH_DATA;
                        cnt   <= len_data;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_DATA: begin
                    if (last) begin
                        phase <= PH_TURN;
                        cnt   <= len_turn;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_TURN: begin
                    if (last) begin
                        phase <= PH_IDLE;
                        ack   <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mms_pin_drive.sv
// Pin decoder: derives the memory strobes and the shared-bus driver
// from the current phase. Purely combinational from registered state.
// Assumes ADDR_W >= BUS_W; the low BUS_W address bits go on the bus.
module mms_pin_drive
    import mms_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  phase_t           phase,
    input  logic             mux_en,
    input  logic             write_q,
    input  logic [1:0]       width,
    input  logic [BUS_W-1:0] addr_lo,
    input  logic [BUS_W-1:0] wdata,
    output logic             cs_n,
    output logic             adv_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_out
);

    localparam logic [BUS_W-1:0] BYTE_MASK = BUS_W'(8'hFF);

    logic in_addr, in_data;
    logic [BUS_W-1:0] mask;

    // Strobe and bus decode per phase
    always_comb begin
        in_addr = (phase == PH_SETUP) || (phase == PH_HOLD);
        in_data = (phase == PH_DATA);
        mask    = (width == 2'b00) ? BYTE_MASK : '1;
        cs_n    = !(in_addr || in_data);
        adv_n   = !((phase == PH_SETUP) && mux_en);
        oe_n    = !(in_data && !write_q);
        we_n    = !(in_data && write_q);
        bus_oe  = (in_addr && mux_en) || (in_data && write_q);
        if (in_addr && mux_en)
            bus_out = addr_lo;
        else if (in_data && write_q)
            bus_out = wdata & mask;
        else
            bus_out = '0;
    end

endmodule

// File: rtl/mms_rd_capture.sv
// Read capture: latches the shared bus on the last read data cycle,
// masked to the programmed width, and holds it for the requester.
module mms_rd_capture #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [1:0]       width,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] rdata
);

    localparam logic [BUS_W-1:0] BYTE_MASK = BUS_W'(8'hFF);

    // Width-masked capture register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (capture)
            rdata <= bus_in & ((width == 2'b00) ? BYTE_MASK : '1);
    end

endmodule

// File: rtl/mux_mem_seq.sv
// Top: multiplexed memory access timing sequencer. Latches the request,
// runs the phase controller and drives the memory pins.
// Assumes ADDR_W >= BUS_W and BUS_W > 8.
module mux_mem_seq
    import mms_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_ack,
    output logic [BUS_W-1:0]  req_rdata,
    output logic              mem_cs_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    input  logic [BUS_W-1:0]  bus_in
);

    localparam int CNT_W = 9;

    cfg_t   cfg_in, cfg_q;
    phase_t phase;
    logic   last, write_q, start;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;

    assign cfg_in   = cfg_t'(cfg_word);
    assign mem_addr = addr_q;

    // Request address and data latched on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    mms_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg       (cfg_in),
        .phase     (phase),
        .last      (last),
        .write_q   (write_q),
        .cfg_q     (cfg_q),
        .start     (start),
        .ack       (req_ack)
    );

    mms_pin_drive #(.BUS_W(BUS_W)) u_pins (
        .phase   (phase),
        .mux_en  (cfg_q.mux_en),
        .write_q (write_q),
        .width   (cfg_q.width),
        .addr_lo (addr_q[BUS_W-1:0]),
        .wdata   (wdata_q),
        .cs_n    (mem_cs_n),
        .adv_n   (mem_adv_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .bus_oe  (bus_oe),
        .bus_out (bus_out)
    );

    mms_rd_capture #(.BUS_W(BUS_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture ((phase == PH_DATA) && last && !write_q),
        .width   (cfg_q.width),
        .bus_in  (bus_in),
        .rdata   (req_rdata)
    );

endmodule

// File: rtl/mms_seq_chk.sv
// Checker: pin-level protocol properties of the sequencer, bound to the top.
module mms_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic adv_n,
    input logic oe_n,
    input logic we_n,
    input logic bus_oe,
    input logic ack
);

    // R6/R7: read and write strobes never active together
    a_r6_no_strobe_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R7: bus driver released whenever the memory may drive
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !bus_oe);

    // R2: strobe only inside a selected access, with the bus driven
    a_r2_adv_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |-> (!cs_n && bus_oe));

    // R6: write enable implies the bus is driven
    a_r6_we_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> bus_oe);

    // R5: acknowledge lasts one cycle
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R5: acknowledge only after chip select has been high (turnaround)
    a_r5_ack_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs_n && $past(cs_n)));

endmodule

bind mux_mem_seq mms_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (mem_cs_n),
    .adv_n  (mem_adv_n),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .bus_oe (bus_oe),
    .ack    (req_ack)
);

// File: tb/mux_mem_seq_bench.sv
`timescale 1ns/1ps
module mux_mem_seq_bench;

    typedef struct packed {
        logic        wr;
        logic        mux;
        logic [1:0]  wid;
        logic [3:0]  su;
        logic [3:0]  ho;
        logic [7:0]  da;
        logic [3:0]  tu;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] base;
        logic [7:0]  exp_total;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 2'b01, 4'd2,  4'd1,  8'd3,  4'd1,  16'hA5C3, 16'h1234, 16'h0000, 8'd11, 16'h0000},
        '{1'b0, 1'b1, 2'b01, 4'd0,  4'd2,  8'd1,  4'd0,  16'h0F0F, 16'h0000, 16'h4000, 8'd9,  16'h4003},
        '{1'b0, 1'b1, 2'b00, 4'd3,  4'd0,  8'd0,  4'd2,  16'h8001, 16'h0000, 16'h12FE, 8'd13, 16'h0001},
        '{1'b1, 1'b0, 2'b00, 4'd1,  4'd0,  8'd0,  4'd0,  16'h3C3C, 16'hBEEF, 16'h0000, 8'd7,  16'h0000},
        '{1'b0, 1'b0, 2'b01, 4'd15, 4'd15, 8'd10, 4'd15, 16'hFFFF, 16'h0000, 16'h7000, 8'd61, 16'h700C},
        '{1'b1, 1'b1, 2'b10, 4'd0,  4'd1,  8'd1,  4'd0,  16'h0001, 16'hCAFE, 16'h0000, 8'd6,  16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic        mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n;
    logic [15:0] mem_addr, bus_out;
    logic        bus_oe;
    logic [15:0] bus_in = '0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mux_mem_seq u_mux_mem_seq (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_cfg(input vec_t v, input logic bank);
        return {v.tu, v.da, v.ho, v.su, v.wid, v.mux, bank};
    endfunction

    // Run one access; alt_cfg is applied mut_at cycles in (0 = never)
    task automatic do_access(input vec_t v, input int mut_at, input logic [23:0] alt_cfg,
                             input logic hold_extra,
                             output int n_tot, output int n_cs, output int n_adv,
                             output int n_addr, output int n_str, output int n_bad);
        int n = 0;
        int ocnt = 0;
        logic [15:0] mask;
        mask = (v.wid == 2'b00) ? 16'h00FF : 16'hFFFF;
        n_tot = -1; n_cs = 0; n_adv = 0; n_addr = 0; n_str = 0; n_bad = 0;
        @(negedge clk);
        cfg_word  = mk_cfg(v, 1'b1);
        req_valid = 1'b1;
        req_write = v.wr;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        bus_in    = 16'h0;
        while (n < 400) begin
            @(negedge clk);
            n++;
            if (mut_at != 0 && n == mut_at) cfg_word = alt_cfg;
            if (req_ack) begin
                n_tot = n - 1;
                if (hold_extra) @(negedge clk);
                req_valid = 1'b0;
                break;
            end
            if (!mem_cs_n) begin
                n_cs++;
                if (mem_addr !== v.addr) n_bad++;
            end
            if (!mem_adv_n) n_adv++;
            if (!mem_cs_n && mem_oe_n && mem_we_n && bus_oe && bus_out === v.addr) n_addr++;
            if (!mem_we_n) begin
                n_str++;
                if (!bus_oe || bus_out !== (v.wdata & mask) || !mem_oe_n) n_bad++;
            end
            if (!mem_oe_n) begin
                n_str++;
                if (bus_oe) n_bad++;
                bus_in = v.base + 16'(ocnt);
                ocnt++;
            end
            if (mem_cs_n && (!mem_oe_n || !mem_we_n || !mem_adv_n)) n_bad++;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t, c, a, ad, s, b;
        int l1, l2, l3, l4, d;
        vec_t v;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 cs_n", mem_cs_n, 1);
        check("R10 adv_n", mem_adv_n, 1);
        check("R10 oe_n", mem_oe_n, 1);
        check("R10 we_n", mem_we_n, 1);
        check("R10 bus_oe", bus_oe, 0);
        check("R10 ack", req_ack, 0);
        check("R10 rdata", req_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2..R8
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            do_access(v, 0, 24'h0, 1'b0, t, c, a, ad, s, b);
            d  = (v.da == 0) ? 1 : int'(v.da);
            l1 = int'(v.su) + 1;
            l2 = ((v.ho == 0) ? 1 : int'(v.ho)) + 1;
            l3 = v.wr ? d + 1 : d + 3;
            l4 = int'(v.tu) + 1;
            check("R5 total latency", t, int'(v.exp_total));
            check("R5 total from fields", t, l1 + l2 + l3 + l4);
            check("R4 cs low cycles", c, l1 + l2 + l3);
            check("R4 strobe cycles", s, l3);
            check("R2 adv low cycles", a, v.mux ? l1 : 0);
            check("R3 R8 address on bus", ad, v.mux ? l1 + l2 : 0);
            check("R6 R8 pin errors", b, 0);
            if (!v.wr) check("R7 read data", req_rdata, int'(v.exp_rd));
            repeat (2) @(negedge clk);
        end

        // R1: bank disabled blocks the access
        v = VEC[5];
        @(negedge clk);
        cfg_word  = mk_cfg(v, 1'b0);
        req_valid = 1'b1;
        req_write = 1'b1;
        c = 0; a = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!mem_cs_n) c++;
            if (req_ack) a++;
        end
        check("R1 no cs with bank off", c, 0);
        check("R1 no ack with bank off", a, 0);
        do_access(v, 0, 24'h0, 1'b0, t, c, a, ad, s, b);
        check("R1 access after bank on", t, 6);

        // R9: config change mid-access has no effect
        repeat (2) @(negedge clk);
        do_access(VEC[0], 2, 24'hFFFFF3, 1'b0, t, c, a, ad, s, b);
        check("R9 config snapshot latency", t, 11);
        check("R9 config snapshot strobe", s, 4);

        // R9: request held in the acknowledge cycle starts nothing
        repeat (2) @(negedge clk);
        do_access(VEC[5], 0, 24'h0, 1'b1, t, c, a, ad, s, b);
        c = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!mem_cs_n) c++;
        end
        check("R9 single access", c, 0);

        // R10: reset in the middle of an access
        v = VEC[4];
        @(negedge clk);
        cfg_word  = mk_cfg(v, 1'b1);
        req_valid = 1'b1;
        req_write = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 access running", mem_cs_n, 0);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 cs after reset", mem_cs_n, 1);
        check("R10 oe after reset", mem_oe_n, 1);
        check("R10 rdata after reset", req_rdata, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 stays idle", mem_cs_n, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule